// File: doc/BRIEF.md
# DDR SDRAM Refresh Sequencer

This block keeps a two-rank DDR SDRAM refreshed. A programmable interval timer raises a refresh request at a fixed period. If refresh is enabled when the timer expires, the block raises a pending request towards the command scheduler. The request is a single flag, so a second expiry before the request is served does not add another refresh.

The scheduler signals, through a grant input, that the command bus is idle. The sequencer then takes the bus and selects both ranks for the whole transaction. If any bank in either rank holds an open row, it first issues a precharge-all. After that it issues auto-refresh, then holds the bus with NOP commands for the programmed refresh recovery time.

When the transaction ends, the block releases the chip selects. It also pulses a signal that tells the bank tracker all rows are now closed. The precharge and recovery times are captured when a transaction starts, so changes made during a transaction take effect only on the next one.

Top module: `ddr_refresh_seq`

## Requirements
- R1: The interval timer expires once every `interval_i` cycles. While refresh is enabled, each expiry sets `rfsh_req_o`, which becomes 1 one cycle after the expiring count. After reset the first request appears `interval_i`+1 cycles after reset is released.
- R2: While `rfsh_en_i` is 0, timer expiries raise no request.
- R3: A transaction starts only while `rfsh_req_o` is 1 and `bus_idle_i` is 1 in the same cycle. Its first command appears in the next cycle. Starting clears the pending request.
- R4: If any bit of `row_open_i` is 1 at the start, the first command is precharge-all. Precharge-all is encoded as `cs_n_o`=00, `ras_n_o`=0, `cas_n_o`=1, `we_n_o`=0 and `ap_o`=1.
- R5: Auto-refresh comes exactly RP cycles after the precharge-all, and every cycle in between carries NOP (ras/cas/we = 1/1/1). When RP is 1, no NOP is inserted.
- R6: If no bit of `row_open_i` is 1 at the start, the transaction begins directly with auto-refresh. Auto-refresh is encoded as `cs_n_o`=00, `ras_n_o`=0, `cas_n_o`=0, `we_n_o`=1 and `ap_o`=0.
- R7: Exactly RFC NOP cycles follow auto-refresh. In the next cycle `cs_n_o` returns to 11.
- R8: Both bits of `cs_n_o` are 0 for every cycle of a transaction, and both are 1 outside it.
- R9: `rows_clr_o` is a one-cycle pulse in the first cycle after a transaction ends.
- R10: Any number of expiries that occur while a request is already pending lead to a single transaction.
- R11: RP and RFC are captured at the start of a transaction. Changing `trp_i` or `trfc_i` during a transaction does not alter its timing.
- R12: Outside a transaction the command pins drive NOP and `ap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rfsh_en_i | input | 1 | Refresh enable |
| interval_i | input | 16 | Refresh period in cycles (minimum 1) |
| trp_i | input | 8 | Precharge time RP in cycles (minimum 1) |
| trfc_i | input | 8 | Refresh recovery time RFC in cycles (minimum 1) |
| row_open_i | input | 8 | Open-row flag for each bank, rank-major (rank r, bank b at bit r*4+b) |
| bus_idle_i | input | 1 | Command bus grant: the bus is idle |
| rfsh_req_o | output | 1 | A refresh is pending |
| cs_n_o | output | 2 | Chip selects, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ap_o | output | 1 | All-banks precharge address bit |
| rows_clr_o | output | 1 | Pulse: all rows are closed |

## Verification
Each result has a fixed delay:
- The request appears one cycle after the timer's last count.
- The first command appears one cycle after a cycle in which both the grant and the request are 1.
- After the first command, every later command falls at a fixed offset set by RP and RFC, and the row-clear pulse lands on the first idle cycle.

The bench drives inputs on the falling edge and samples outputs on the falling edge. It counts cycles from the first command and compares each cycle against a sequence built from RP, RFC and the row-open state. The precharge and recovery inputs are changed right after the first command to show that the captured values govern the rest of the transaction.

// File: rtl/ddr_rfsh_pkg.sv
package ddr_rfsh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_PWAIT = 3'd2,
    ST_REF   = 3'd3,
    ST_RWAIT = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t enc_cmd(cmd_e c);
    cmd_pins_t p;
    case (c)
      CMD_PRE: p = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default: p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] interval_i,
  input  logic          en_i,
  input  logic          start_i,
  output logic          req_o
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt_q;
  logic          pend_q;
  logic          tick;

  assign tick = (cnt_q == ONE);

  // 0 only after reset: load without expiring
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q <= ONE) begin
      cnt_q <= interval_i;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // single flag: repeated expiries collapse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~start_i) | (tick & en_i);
  end

  assign req_o = pend_q;
endmodule

// File: rtl/rfsh_open_detect.sv
module rfsh_open_detect #(
  parameter int unsigned RANKS = 2,
  parameter int unsigned BANKS = 4
) (
  input  logic [RANKS*BANKS-1:0] row_open_i,
  output logic                   any_open_o
);
  logic [RANKS-1:0] rank_open;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    assign rank_open[r] = |row_open_i[r*BANKS +: BANKS];
  end

  assign any_open_o = |rank_open;
endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
  import ddr_rfsh_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          bus_idle_i,
  input  logic          any_open_i,
  input  logic [TW-1:0] trp_i,
  input  logic [TW-1:0] trfc_i,
  output logic          start_o,
  output logic          active_o,
  output cmd_e          cmd_o,
  output logic          done_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  seq_st_e       st_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] rfc_q;
  logic          done_q;

  assign start_o = (st_q == ST_IDLE) && req_i && bus_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rfc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_o) begin
            rfc_q <= trfc_i;
            cnt_q <= trp_i;
            st_q  <= any_open_i ? ST_PRE : ST_REF;
          end
        end
        ST_PRE, ST_PWAIT: begin
          if (cnt_q <= ONE) begin
            st_q <= ST_REF;
          end else begin
            cnt_q <= cnt_q - ONE;
            st_q  <= ST_PWAIT;
          end
        end
        ST_REF: begin
          cnt_q <= rfc_q;
          st_q  <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (cnt_q <= ONE) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_PRE:  cmd_o = CMD_PRE;
      ST_REF:  cmd_o = CMD_REF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign active_o = (st_q != ST_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ddr_rfsh_pkg::*;
#(
  parameter int unsigned RANKS = 2,
  parameter int unsigned BANKS = 4,
  parameter int unsigned IW    = 16,
  parameter int unsigned TW    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rfsh_en_i,
  input  logic [IW-1:0]          interval_i,
  input  logic [TW-1:0]          trp_i,
  input  logic [TW-1:0]          trfc_i,
  input  logic [RANKS*BANKS-1:0] row_open_i,
  input  logic                   bus_idle_i,
  output logic                   rfsh_req_o,
  output logic [RANKS-1:0]       cs_n_o,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic                   ap_o,
  output logic                   rows_clr_o
);
  logic      req, start, any_open, active, done;
  cmd_e      cmd;
  cmd_pins_t pins;

  rfsh_timer #(.IW(IW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .interval_i (interval_i),
    .en_i       (rfsh_en_i),
    .start_i    (start),
    .req_o      (req)
  );

  rfsh_open_detect #(.RANKS(RANKS), .BANKS(BANKS)) i_open (
    .row_open_i (row_open_i),
    .any_open_o (any_open)
  );

  rfsh_seq_fsm #(.TW(TW)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .bus_idle_i (bus_idle_i),
    .any_open_i (any_open),
    .trp_i      (trp_i),
    .trfc_i     (trfc_i),
    .start_o    (start),
    .active_o   (active),
    .cmd_o      (cmd),
    .done_o     (done)
  );

  assign pins       = enc_cmd(cmd);
  assign cs_n_o     = active ? '0 : '1;
  assign ras_n_o    = pins.ras_n;
  assign cas_n_o    = pins.cas_n;
  assign we_n_o     = pins.we_n;
  assign ap_o       = (cmd == CMD_PRE);
  assign rfsh_req_o = req;
  assign rows_clr_o = done;
endmodule

// File: rtl/ddr_refresh_seq_chk.sv
module ddr_refresh_seq_chk #(
  parameter int unsigned RANKS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_idle_i,
  input logic             rfsh_req_o,
  input logic [RANKS-1:0] cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic             ap_o,
  input logic             rows_clr_o
);
  logic sel, desel, is_pre, is_ref, is_nop;
  assign sel    = ~|cs_n_o;
  assign desel  = &cs_n_o;
  assign is_pre = sel && !ras_n_o && cas_n_o && !we_n_o;
  assign is_ref = sel && !ras_n_o && !cas_n_o && we_n_o;
  assign is_nop = ras_n_o && cas_n_o && we_n_o;

  a_r8_cs_all_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel || desel);

  a_r12_idle_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |-> (is_nop && !ap_o));

  a_r4_ap_with_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |-> is_pre);

  a_r3_start_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o[0]) |-> ($past(bus_idle_i) && $past(rfsh_req_o)));

  a_r7_nop_after_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |=> (sel && is_nop));

  a_r5_pre_not_repeated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |=> !is_pre);

  a_r9_clr_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rows_clr_o |-> (desel && $past(sel)));

  a_r9_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rows_clr_o |=> !rows_clr_o);
endmodule

bind ddr_refresh_seq ddr_refresh_seq_chk #(.RANKS(RANKS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_idle_i (bus_idle_i),
  .rfsh_req_o (rfsh_req_o),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .ap_o       (ap_o),
  .rows_clr_o (rows_clr_o)
);

// File: tb/test_ddr_refresh_seq.sv
`timescale 1ns/1ps
module test_ddr_refresh_seq;
  localparam int IW = 16;
  localparam int TW = 8;
  localparam int IVL = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rfsh_en_i = 1'b0;
  logic [IW-1:0] interval_i = IW'(IVL);
  logic [TW-1:0] trp_i = 8'd2;
  logic [TW-1:0] trfc_i = 8'd2;
  logic [7:0]    row_open_i = '0;
  logic          bus_idle_i = 1'b0;
  logic          rfsh_req_o, ras_n_o, cas_n_o, we_n_o, ap_o, rows_clr_o;
  logic [1:0]    cs_n_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_refresh_seq i_ddr_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .rfsh_en_i(rfsh_en_i), .interval_i(interval_i),
    .trp_i(trp_i), .trfc_i(trfc_i), .row_open_i(row_open_i), .bus_idle_i(bus_idle_i),
    .rfsh_req_o(rfsh_req_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ap_o(ap_o), .rows_clr_o(rows_clr_o)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    bus_idle_i = 1'b0;
    cyc();
    rst_ni = 1'b1;
  endtask

  // pin bundle: {cs_n[1:0], ras, cas, we, ap}
  function automatic int pins_now();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o, ap_o};
  endfunction

  localparam int P_IDLE = 6'b11_111_0;
  localparam int P_NOP  = 6'b00_111_0;
  localparam int P_PRE  = 6'b00_010_1;
  localparam int P_REF  = 6'b00_001_0;

  task automatic t_reset();
    do_reset();
    chk("R12", "reset pins", pins_now(), P_IDLE);
    chk("R1", "reset req", int'(rfsh_req_o), 0);
    chk("R9", "reset clr", int'(rows_clr_o), 0);
  endtask

  task automatic t_interval();
    rfsh_en_i = 1'b1;
    do_reset();
    for (int k = 1; k <= IVL + 1; k++) begin
      cyc();
      if (k == IVL)     chk("R1", "req before expiry", int'(rfsh_req_o), 0);
      if (k == IVL + 1) chk("R1", "req after expiry", int'(rfsh_req_o), 1);
    end
  endtask

  task automatic t_disabled();
    rfsh_en_i = 1'b0;
    do_reset();
    for (int k = 0; k < 4 * IVL; k++) begin
      cyc();
      if (rfsh_req_o) begin
        chk("R2", "req while disabled", 1, 0);
        break;
      end
    end
    chk("R2", "no req after 4 periods", int'(rfsh_req_o), 0);
  endtask

  task automatic wait_req();
    for (int k = 0; k < 100 && !rfsh_req_o; k++) cyc();
    chk("R1", "request raised", int'(rfsh_req_o), 1);
  endtask

  task automatic run_seq(input logic [7:0] open, input int rp, input int rfc);
    int pre_n, total;
    rfsh_en_i  = 1'b1;
    row_open_i = open;
    trp_i      = TW'(rp);
    trfc_i     = TW'(rfc);
    wait_req();
    cyc();
    chk("R3", "held off without grant", pins_now(), P_IDLE);
    bus_idle_i = 1'b1;
    cyc();
    bus_idle_i = 1'b0;
    trp_i      = TW'(rp + 5);   // must not affect this transaction (R11)
    trfc_i     = TW'(rfc + 7);
    row_open_i = ~open;
    pre_n = (open != 0) ? rp : 0;
    total = pre_n + 1 + rfc;
    for (int t = 0; t <= total; t++) begin
      int e;
      if (t == total)            e = P_IDLE;
      else if (open != 0 && t == 0) e = P_PRE;
      else if (t == pre_n)       e = P_REF;
      else                       e = P_NOP;
      if (t == 0)
        chk((open != 0) ? "R4" : "R6", "first command", pins_now(), e);
      else if (t < pre_n)
        chk("R5", "precharge gap", pins_now(), e);
      else if (t == pre_n)
        chk((open != 0) ? "R5" : "R6", "refresh slot", pins_now(), e);
      else if (t < total)
        chk("R7", "recovery nop", pins_now(), e);
      else
        chk("R7", "release", pins_now(), e);
      if (t < total) chk("R8", "cs held", int'(cs_n_o), 0);
      if (t == total) chk("R9", "clr at end", int'(rows_clr_o), 1);
      else            chk("R9", "clr quiet", int'(rows_clr_o), 0);
      if (t != total) cyc();
    end
    cyc();
    chk("R9", "clr one cycle", int'(rows_clr_o), 0);
    chk("R12", "idle after", pins_now(), P_IDLE);
    row_open_i = '0;
  endtask

  task automatic t_single();
    int starts = 0;
    logic prev_cs;
    rfsh_en_i = 1'b1;
    row_open_i = '0;
    trp_i = 8'd1;
    trfc_i = 8'd2;
    do_reset();
    for (int k = 0; k < 4 * IVL; k++) cyc();
    chk("R10", "pending after many expiries", int'(rfsh_req_o), 1);
    rfsh_en_i = 1'b0;
    bus_idle_i = 1'b1;
    prev_cs = 1'b1;
    for (int k = 0; k < 40; k++) begin
      cyc();
      if (prev_cs && !cs_n_o[0]) starts++;
      prev_cs = cs_n_o[0];
    end
    bus_idle_i = 1'b0;
    chk("R10", "transactions", starts, 1);
    chk("R10", "request cleared", int'(rfsh_req_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interval();
    t_disabled();
    run_seq(8'b0000_0100, 3, 4);
    run_seq(8'b1000_0000, 1, 1);
    run_seq(8'b0000_0000, 2, 3);
    run_seq(8'b0001_0000, 2, 1);
    t_single();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule